// File: doc/BRIEF.md
# Word-Interleaved Four-Bank Block Fill Controller

This controller serves cache-block fill requests from a set of independent memory banks laid out with word interleaving. The word address of word i in block b is b times the bank count plus i, so the low word-address bits pick the bank and the remaining bits pick the row inside it. Every word of a block therefore lives in a different bank. All banks of the block can then be started in the same cycle, and their results arrive together. The controller streams them back one word per cycle, in ascending order, over a one-word bus, and tags each word with its index.

The requester offers a block address with a valid/ready handshake. After acceptance the controller sends the row address to every bank with a one-cycle request pulse. It waits for the banks' read-valid strobes, captures the returned words and delivers them. Ready stays low for the whole fill. Each bank has a busy countdown covering its cycle time, and a fill is held back until every bank it needs has finished its previous cycle. The length of each fill, in cycles from acceptance to the last delivered word, is reported on a debug output. With a one-cycle address transfer, a ten-cycle bank access and four words, a fill on idle banks costs 1 + 10 + 1 + 3 = 15 cycles. The same fill served by one bank without interleaving would cost 48.

Top module: `ilv_fill_ctrl`

## Requirements
- R1: Word i (i = 0..3) of block b is the word at word address 4*b+i, which is read from bank i at row b. The banks take one shared row output and per-bank request bits, where bit i of bank_req and of bank_rvalid belongs to bank i and bank_rdata bits [32*i+31:32*i] carry its word.
- R2: When a request is accepted and all banks are free, bank_req is driven to all ones for exactly one cycle, in the cycle after acceptance, with bank_row equal to the accepted block address. At all other times bank_req is zero.
- R3: A bank is never requested again until BANK_CYCLE cycles (default 10) after its previous request. A fill whose banks are still busy is held until they are free.
- R4: The four words of a block appear on out_data with out_valid high in four consecutive cycles, with out_idx counting 0, 1, 2, 3.
- R5: With free banks and banks that answer 10 cycles after their request, the last word of a fill appears 15 cycles after the acceptance edge.
- R6: req_ready is low from the acceptance edge until the last word of the block has been delivered. It is high again in the cycle that shows the last word, so a held request is taken at the next edge.
- R7: fill_done pulses high together with the last word of a fill, and fill_cycles then holds the number of cycles from acceptance to that last word.
- R8: After reset, req_ready is high, out_valid and fill_done are low, bank_req is zero and fill_cycles is zero.
- R9: When a fill must wait for busy banks, it costs 15 cycles plus the cycles it waited. With BANK_CYCLE = 20, a fill accepted g cycles after the previous fill ended takes 15 + max(0, 4 - g) cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | A fill request is offered |
| req_ready | output | 1 | Controller can take a request |
| req_blk | input | ROW_W | Block address of the fill |
| bank_req | output | NBANK | Per-bank access start pulse |
| bank_row | output | ROW_W | Row address shared by all banks |
| bank_rvalid | input | NBANK | Per-bank read data valid strobe |
| bank_rdata | input | NBANK*DATA_W | Read data, bank i in slice i |
| out_valid | output | 1 | A block word is on out_data |
| out_data | output | DATA_W | Delivered word |
| out_idx | output | log2(NBANK) | Index of the word within its block |
| fill_done | output | 1 | Last word of a fill is on the bus |
| fill_cycles | output | CNT_W | Length of the most recent fill in cycles |

## Verification
A wrong busy countdown shows up on the second of two back-to-back fills. The bank models then see a request inside their cycle time, and fill_cycles and the first bank_req pulse land earlier or later than the computed stall allows. A wrong read pointer or a lost filled flag in the capture buffer shows up as words out of order or as a data mismatch at out_idx within the same fill. A stuck state shows up as a missing word or as req_ready staying low, which the per-fill cycle limit catches within about fifty cycles.

// File: rtl/ilv_pkg.sv
package ilv_pkg;

   typedef enum logic [1:0] {
      FS_IDLE    = 2'd0,
      FS_ISSUE   = 2'd1,
      FS_COLLECT = 2'd2
   } fill_state_t;

   function automatic bit is_pow2(input int unsigned v);
      return (v != 0) && ((v & (v - 1)) == 0);
   endfunction

endpackage

// File: rtl/ilv_bank_timer.sv
module ilv_bank_timer #(
   parameter int unsigned NBANK      = 4,
   parameter int unsigned BANK_CYCLE = 10
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [NBANK-1:0] issue,
   output logic [NBANK-1:0] free
);
   localparam int unsigned TW = (BANK_CYCLE > 1) ? $clog2(BANK_CYCLE) : 1;

   genvar b;
   generate
      if (BANK_CYCLE <= 1) begin : g_no_wait
         assign free = '1;
      end else begin : g_countdown
         for (b = 0; b < NBANK; b++) begin : g_bank
            logic [TW-1:0] remain;

            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) begin
                  remain <= '0;
               end else if (issue[b]) begin
                  remain <= TW'(BANK_CYCLE - 1);
               end else if (remain != '0) begin
                  remain <= remain - 1'b1;
               end
            end

            assign free[b] = (remain == '0);

            // R3: a bank is never started while its cycle time is running
            assert_issue_when_free_R3: assert property (
               @(posedge clk) disable iff (!rst_n)
               issue[b] |-> free[b]);

            // R3: right after a start the bank reports busy
            assert_busy_after_issue_R3: assert property (
               @(posedge clk) disable iff (!rst_n)
               issue[b] |=> !free[b]);
         end
      end
   endgenerate

endmodule

// File: rtl/ilv_word_buffer.sv
module ilv_word_buffer #(
   parameter int unsigned NBANK  = 4,
   parameter int unsigned DATA_W = 32
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    clear,
   input  logic [NBANK-1:0]        rvalid,
   input  logic [NBANK*DATA_W-1:0] rdata,
   output logic [NBANK-1:0]        filled,
   output logic [NBANK*DATA_W-1:0] words
);

   genvar b;
   generate
      for (b = 0; b < NBANK; b++) begin : g_slot
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               filled[b]                  <= 1'b0;
               words[b*DATA_W +: DATA_W]  <= '0;
            end else if (clear) begin
               filled[b]                  <= 1'b0;
            end else if (rvalid[b]) begin
               filled[b]                  <= 1'b1;
               words[b*DATA_W +: DATA_W]  <= rdata[b*DATA_W +: DATA_W];
            end
         end

         // R1: each bank answers once per fill, so no slot is overwritten
         assert_no_overwrite_R1: assert property (
            @(posedge clk) disable iff (!rst_n)
            (rvalid[b] && !clear) |-> !filled[b]);
      end
   endgenerate

endmodule

// File: rtl/ilv_word_seq.sv
module ilv_word_seq #(
   parameter int unsigned NBANK  = 4,
   parameter int unsigned DATA_W = 32,
   localparam int unsigned IW    = $clog2(NBANK)
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    active,
   input  logic [NBANK-1:0]        filled,
   input  logic [NBANK*DATA_W-1:0] words,
   output logic                    out_valid,
   output logic [DATA_W-1:0]       out_data,
   output logic [IW-1:0]           out_idx,
   output logic                    last_emit
);
   localparam logic [IW-1:0] LAST_IDX = IW'(NBANK - 1);

   logic [IW-1:0] nxt;
   logic          emit;

   assign emit      = active && filled[nxt];
   assign last_emit = emit && (nxt == LAST_IDX);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         nxt       <= '0;
         out_valid <= 1'b0;
         out_data  <= '0;
         out_idx   <= '0;
      end else begin
         out_valid <= emit;
         if (emit) begin
            out_data <= words[nxt*DATA_W +: DATA_W];
            out_idx  <= nxt;
            nxt      <= (nxt == LAST_IDX) ? '0 : nxt + 1'b1;
         end else if (!active) begin
            nxt      <= '0;
         end
      end
   end

   // R4: inside a block the word index steps by one between adjacent words
   assert_idx_ascending_R4: assert property (
      @(posedge clk) disable iff (!rst_n)
      (out_valid && $past(out_valid) && out_idx != '0) |->
         (out_idx == IW'($past(out_idx) + 1'b1)));

   // R4: once a block has started, its next word follows in the next cycle
   assert_no_gap_R4: assert property (
      @(posedge clk) disable iff (!rst_n)
      (out_valid && out_idx != LAST_IDX) |=> out_valid);

endmodule

// File: rtl/ilv_fill_ctrl.sv
module ilv_fill_ctrl
   import ilv_pkg::*;
#(
   parameter int unsigned NBANK      = 4,
   parameter int unsigned DATA_W     = 32,
   parameter int unsigned ROW_W      = 8,
   parameter int unsigned BANK_CYCLE = 10,
   parameter int unsigned CNT_W      = 8,
   localparam int unsigned IW        = $clog2(NBANK)
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    req_valid,
   output logic                    req_ready,
   input  logic [ROW_W-1:0]        req_blk,
   output logic [NBANK-1:0]        bank_req,
   output logic [ROW_W-1:0]        bank_row,
   input  logic [NBANK-1:0]        bank_rvalid,
   input  logic [NBANK*DATA_W-1:0] bank_rdata,
   output logic                    out_valid,
   output logic [DATA_W-1:0]       out_data,
   output logic [IW-1:0]           out_idx,
   output logic                    fill_done,
   output logic [CNT_W-1:0]        fill_cycles
);

   generate
      if (!is_pow2(NBANK) || NBANK < 2) begin : g_bad_nbank
         $error("ilv_fill_ctrl: NBANK must be a power of two, at least 2");
      end
      if (DATA_W < 1 || ROW_W < 1) begin : g_bad_width
         $error("ilv_fill_ctrl: DATA_W and ROW_W must be positive");
      end
      if (CNT_W < 5) begin : g_bad_cnt
         $error("ilv_fill_ctrl: CNT_W too narrow for a fill length");
      end
   endgenerate

   fill_state_t      state;
   logic [ROW_W-1:0] blk_q;
   logic [CNT_W-1:0] cyc_cnt;
   logic [NBANK-1:0] bank_free;
   logic [NBANK-1:0] issue_vec;
   logic [NBANK-1:0] filled;
   logic [NBANK*DATA_W-1:0] words;
   logic             accept;
   logic             issue_fire;
   logic             last_emit;

   assign req_ready  = (state == FS_IDLE);
   assign accept     = req_valid && req_ready;
   assign issue_fire = (state == FS_ISSUE) && (&bank_free);
   assign issue_vec  = {NBANK{issue_fire}};
   assign bank_row   = blk_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state <= FS_IDLE;
         blk_q <= '0;
      end else begin
         case (state)
            FS_IDLE: begin
               if (req_valid) begin
                  state <= FS_ISSUE;
                  blk_q <= req_blk;
               end
            end
            FS_ISSUE: begin
               if (&bank_free) state <= FS_COLLECT;
            end
            FS_COLLECT: begin
               if (last_emit) state <= FS_IDLE;
            end
            default: state <= FS_IDLE;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         bank_req <= '0;
      end else begin
         bank_req <= issue_vec;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cyc_cnt     <= '0;
         fill_cycles <= '0;
         fill_done   <= 1'b0;
      end else begin
         fill_done <= last_emit;
         if (accept) begin
            cyc_cnt <= '0;
         end else if (state != FS_IDLE) begin
            cyc_cnt <= cyc_cnt + 1'b1;
         end
         if (last_emit) begin
            fill_cycles <= cyc_cnt + 1'b1;
         end
      end
   end

   ilv_bank_timer #(
      .NBANK      (NBANK),
      .BANK_CYCLE (BANK_CYCLE)
   ) timer_i (
      .clk   (clk),
      .rst_n (rst_n),
      .issue (issue_vec),
      .free  (bank_free)
   );

   ilv_word_buffer #(
      .NBANK  (NBANK),
      .DATA_W (DATA_W)
   ) buffer_i (
      .clk    (clk),
      .rst_n  (rst_n),
      .clear  (accept),
      .rvalid (bank_rvalid),
      .rdata  (bank_rdata),
      .filled (filled),
      .words  (words)
   );

   ilv_word_seq #(
      .NBANK  (NBANK),
      .DATA_W (DATA_W)
   ) seq_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .active    (state == FS_COLLECT),
      .filled    (filled),
      .words     (words),
      .out_valid (out_valid),
      .out_data  (out_data),
      .out_idx   (out_idx),
      .last_emit (last_emit)
   );

   // R2: banks are always started together
   assert_all_banks_R2: assert property (
      @(posedge clk) disable iff (!rst_n)
      (bank_req != '0) |-> (&bank_req));

   // R2: the start is a single-cycle pulse
   assert_req_pulse_R2: assert property (
      @(posedge clk) disable iff (!rst_n)
      (bank_req != '0) |=> (bank_req == '0));

   // R6: no new request is taken while words of a block are still pending
   assert_ready_low_R6: assert property (
      @(posedge clk) disable iff (!rst_n)
      (out_valid && !fill_done) |-> !req_ready);

   // R7: the done pulse comes with the last word of the block
   assert_done_last_R7: assert property (
      @(posedge clk) disable iff (!rst_n)
      fill_done |-> (out_valid && out_idx == IW'(NBANK - 1)));

endmodule

// File: tb/ilv_fill_ctrl_tb_top.sv
`timescale 1ns/1ps

module ilv_bank_model_tb #(
   parameter int unsigned BANK   = 0,
   parameter int unsigned NBANK  = 4,
   parameter int unsigned ROW_W  = 8,
   parameter int unsigned LAT    = 10,
   parameter int unsigned CYC    = 10
) (
   input  logic             clk,
   input  logic             req,
   input  logic [ROW_W-1:0] row,
   output logic             rvalid,
   output logic [31:0]      rdata,
   output logic             viol
);
   int unsigned rem;
   int unsigned since;
   logic [ROW_W-1:0] row_q;

   initial begin
      rvalid = 1'b0;
      rdata  = '0;
      viol   = 1'b0;
      rem    = 0;
      since  = CYC;
      row_q  = '0;
   end

   always @(negedge clk) begin
      rvalid <= 1'b0;
      if (since < CYC) since = since + 1;
      if (req) begin
         if (since < CYC) viol <= 1'b1;
         since = 0;
         rem   = LAT - 1;
         row_q = row;
      end else if (rem > 0) begin
         rem = rem - 1;
         if (rem == 0) begin
            rvalid <= 1'b1;
            rdata  <= (32'(row_q) * NBANK + BANK) * 32'h0001_0003 ^ 32'hA5C3_0F00;
         end
      end
   end
endmodule

module ilv_fill_ctrl_tb_top;
   localparam int NB = 4;
   localparam int RW = 8;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #2.5 clk = ~clk;

   logic [1:0]        rv;
   logic [1:0]        rdy;
   logic [RW-1:0]     blk [2];
   logic [NB-1:0]     breq [2];
   logic [RW-1:0]     brow [2];
   logic [NB-1:0]     brv [2];
   logic [NB*32-1:0]  brd [2];
   logic [NB-1:0]     bviol [2];
   logic [1:0]        ov;
   logic [31:0]       od [2];
   logic [1:0]        oi [2];
   logic [1:0]        fd;
   logic [7:0]        fc [2];

   int total = 0;
   int bad = 0;
   bit fin = 0;

   for (genvar u = 0; u < 2; u++) begin : g_unit
      ilv_fill_ctrl #(
         .NBANK(NB), .DATA_W(32), .ROW_W(RW),
         .BANK_CYCLE((u == 0) ? 10 : 20), .CNT_W(8)
      ) dut_i (
         .clk(clk), .rst_n(rst_n),
         .req_valid(rv[u]), .req_ready(rdy[u]), .req_blk(blk[u]),
         .bank_req(breq[u]), .bank_row(brow[u]),
         .bank_rvalid(brv[u]), .bank_rdata(brd[u]),
         .out_valid(ov[u]), .out_data(od[u]), .out_idx(oi[u]),
         .fill_done(fd[u]), .fill_cycles(fc[u])
      );
      for (genvar b = 0; b < NB; b++) begin : g_bank
         ilv_bank_model_tb #(
            .BANK(b), .NBANK(NB), .ROW_W(RW), .LAT(10),
            .CYC((u == 0) ? 10 : 20)
         ) bank_i (
            .clk(clk), .req(breq[u][b]), .row(brow[u]),
            .rvalid(brv[u][b]), .rdata(brd[u][b*32 +: 32]),
            .viol(bviol[u][b])
         );
      end
   end

   function automatic logic [31:0] exp_word(input logic [RW-1:0] b, input int i);
      return (32'(b) * NB + 32'(i)) * 32'h0001_0003 ^ 32'hA5C3_0F00;
   endfunction

   task automatic check(input bit ok, input string req, input string what,
                        input longint act, input longint expv);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, expv);
      end
   endtask

   // Table: {block address, idle gap before request, expected fill cycles}
   localparam logic [23:0] VEC [0:7] = '{
      {8'h00, 8'd0, 8'd15}, {8'h01, 8'd0, 8'd15},
      {8'h7F, 8'd3, 8'd15}, {8'hFF, 8'd0, 8'd15},
      {8'h05, 8'd1, 8'd15}, {8'h80, 8'd0, 8'd15},
      {8'hAA, 8'd2, 8'd15}, {8'h3C, 8'd0, 8'd15}
   };

   task automatic do_fill(input int u, input logic [RW-1:0] b, input int gap,
                          input int expc);
      bit was_rdy;
      bit ready_bad = 0;
      int nexp = 0;
      int lastk = 0;
      int nreq = 0;
      int reqk = -1;
      bit got_last = 0;
      repeat (gap) @(negedge clk);
      rv[u]  = 1'b1;
      blk[u] = b;
      forever begin
         was_rdy = rdy[u];
         @(posedge clk);
         if (was_rdy) break;
      end
      @(negedge clk);
      rv[u]  = 1'b0;
      blk[u] = ~b;
      for (int k = 0; k <= 60; k++) begin
         if (breq[u] != '0) begin
            nreq++;
            reqk = k;
            check(breq[u] == '1, "R2", "all banks started together", breq[u], 4'hF);
            check(brow[u] == b, "R1", "row address to banks", brow[u], b);
         end
         if (ov[u]) begin
            check(oi[u] == nexp[1:0], "R4", "word index order", oi[u], nexp);
            check(od[u] == exp_word(b, nexp), "R1", "word data", od[u], exp_word(b, nexp));
            if (nexp > 0)
               check(k == lastk + 1, "R4", "consecutive word cycles", k, lastk + 1);
            lastk = k;
            nexp++;
         end
         if (ov[u] && oi[u] == 2'd3) begin
            check(fd[u] == 1'b1, "R7", "fill_done with last word", fd[u], 1);
            check(fc[u] == 8'(expc), (expc == 15) ? "R5" : "R9",
                  "fill_cycles", fc[u], expc);
            check(k == expc, "R7", "measured fill length", k, expc);
            check(rdy[u] == 1'b1, "R6", "ready high with last word", rdy[u], 1);
            check(nreq == 1 && reqk == expc - 14, "R3", "bank start cycle",
                  reqk, expc - 14);
            got_last = 1;
            break;
         end else if (rdy[u] || fd[u]) begin
            ready_bad = 1;
         end
         @(negedge clk);
      end
      check(got_last, "R4", "all four words delivered", nexp, 4);
      check(!ready_bad, "R6", "ready low during fill", ready_bad, 0);
   endtask

   initial begin
      rv = '0;
      blk[0] = '0;
      blk[1] = '0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      for (int u = 0; u < 2; u++) begin
         check(rdy[u] == 1'b1, "R8", "reset ready", rdy[u], 1);
         check(ov[u] == 1'b0 && fd[u] == 1'b0, "R8", "reset out_valid/fill_done",
               {ov[u], fd[u]}, 0);
         check(breq[u] == '0, "R8", "reset bank_req", breq[u], 0);
         check(fc[u] == '0, "R8", "reset fill_cycles", fc[u], 0);
      end

      for (int v = 0; v < 8; v++)
         do_fill(0, VEC[v][23:16], int'(VEC[v][15:8]), int'(VEC[v][7:0]));

      // Long bank cycle time: stalls behind busy banks (R9, R3)
      do_fill(1, 8'h11, 0, 15);
      do_fill(1, 8'h12, 0, 19);
      do_fill(1, 8'h13, 2, 17);
      do_fill(1, 8'h14, 6, 15);
      do_fill(1, 8'hFE, 0, 19);

      repeat (25) @(negedge clk);
      check(bviol[0] == '0, "R3", "unit0 bank cycle time respected", bviol[0], 0);
      check(bviol[1] == '0, "R3", "unit1 bank cycle time respected", bviol[1], 0);
      check(ov == 2'b00 && breq[0] == '0 && breq[1] == '0, "R2",
            "quiet when idle", {ov, breq[0], breq[1]}, 0);

      fin = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!fin) begin
         total++;
         bad++;
         $display("FAIL R5 watchdog: run hung, actual=hung expected=done");
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

endmodule